// File: doc/BRIEF.md
# Packed SIMD Saturating Lane ALU

This block is a purely combinational lane-parallel arithmetic unit for a 64-bit media register. A one-bit format choice splits the register into one of two lane layouts. The byte layout gives eight unsigned 8-bit lanes, with lane i at bits [8i+7:8i]. The halfword layout gives four two's-complement 16-bit lanes, with lane i at bits [16i+15:16i]. Every lane applies the same operation, chosen by a 4-bit operation code, to one lane of the first vector and the matching lane of a second operand.

The second operand can be built in three ways: the second vector lane by lane, one lane of the second vector copied to every lane, or a 5-bit immediate copied to every lane. Arithmetic results clamp to the lane's range and never wrap. A few operations exist in only one format. Asking for an operation in a format that does not support it, or using the spare code, produces an all-zero result and raises a flag.

Top module: `simd_sat_alu`

## Requirements
- R1: Bit 0 of `fmtSel` chooses the format. 0 gives eight unsigned byte lanes (lane i at bits 8i+7:8i). 1 gives four signed halfword lanes (lane i at bits 16i+15:16i).
- R2: `fmtSel[4:3]` chooses the second operand. If bit 4 is 0, one lane of `vecB` is broadcast. 2'b10 uses `vecB` lane by lane. 2'b11 broadcasts `immVal`, zero-extended to the lane width.
- R3: In broadcast-lane mode the lane index is `fmtSel[3:1]` for bytes (bit offset 8×index) and `fmtSel[3:2]` for halfwords (bit offset 16×index).
- R4: Codes 0, 1, 2 and 3 give bitwise AND, NOR, OR and XOR of each lane pair.
- R5: Code 4 is a logical left shift and code 5 a logical right shift. Code 12 is an arithmetic right shift and exists for halfwords only. The shift count is the low 3 bits of the operand lane for bytes and the low 4 bits for halfwords.
- R6: Code 6 is add and code 7 is subtract. Byte add clamps at 255 and byte subtract floors at 0. Halfword add and subtract clamp to the range -32768..32767.
- R7: Code 10 is multiply. The byte product clamps at 255. The halfword product clamps to -32768..32767.
- R8: Code 8 is minimum and code 9 is maximum. Byte lanes compare as unsigned values and halfword lanes compare as signed values.
- R9: Code 11 is sign transfer and exists for halfwords only. The result is 0 when the first lane is 0, the second lane when the first lane is positive, and the negated second lane when the first lane is negative, with -32768 giving 32767.
- R10: Codes 13 and 14 exist for bytes only. Code 13 gives the absolute difference. Code 14 gives the rounded average (a+b+1)>>1, computed without overflow.
- R11: Codes 11 and 12 in byte format, codes 13 and 14 in halfword format, and code 15 in either format drive `result` to zero and `illegalOp` to 1. Every other combination drives `illegalOp` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vecA | input | 64 | First packed operand |
| vecB | input | 64 | Second packed vector, used whole or as a lane source |
| opCode | input | 4 | Lane operation code |
| fmtSel | input | 5 | Format bit, lane index and operand-mode field |
| immVal | input | 5 | Immediate for broadcast mode |
| result | output | 64 | Packed lane results |
| illegalOp | output | 1 | Unsupported operation/format combination |

## Verification
The block holds no state. A bad decode or a bad lane datapath therefore shows on `result` or `illegalOp` in the same cycle as the stimulus that triggers it. Faults in the operand builder and the lane logic can be hidden by each other. The internal broadcast operand is therefore checked against `vecB` and `immVal` on its own. In addition, result lanes are compared with a bench model on every clock, across all operand modes and across clamp boundaries.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  parameter int unsigned VEC_W      = 64;
  parameter int unsigned IMM_W      = 5;
  parameter int unsigned BYTE_W     = 8;
  parameter int unsigned HALF_W     = 16;
  parameter int unsigned BYTE_LANES = VEC_W / BYTE_W;
  parameter int unsigned HALF_LANES = VEC_W / HALF_W;
  parameter int unsigned BYTE_IDX_W = $clog2(BYTE_LANES);
  parameter int unsigned HALF_IDX_W = $clog2(HALF_LANES);

  typedef enum logic [3:0] {
    OP_AND = 4'd0, OP_NOR = 4'd1, OP_OR = 4'd2, OP_XOR = 4'd3,
    OP_SLL = 4'd4, OP_SRL = 4'd5, OP_ADD = 4'd6, OP_SUB = 4'd7,
    OP_MIN = 4'd8, OP_MAX = 4'd9, OP_MUL = 4'd10, OP_SGN = 4'd11,
    OP_SRA = 4'd12, OP_ABD = 4'd13, OP_AVG = 4'd14, OP_RSV = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] { SRC_ELEM, SRC_VECT, SRC_IMM } srcMode_e;

  // strobes for the operand builder
  typedef struct packed {
    logic                  halfMode;
    srcMode_e              srcMode;
    logic [BYTE_IDX_W-1:0] laneIdx;
  } selCtrl_t;

  // strobes for the lane datapath
  typedef struct packed {
    logic   halfMode;
    aluOp_e op;
    logic   illegal;
  } laneCtrl_t;
endpackage

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic [4:0] fmtSel,
  output selCtrl_t   selCtrl,
  output laneCtrl_t  laneCtrl
);
  logic   isHalf;
  aluOp_e opDec;

  assign isHalf = fmtSel[0];
  assign opDec  = aluOp_e'(opCode);

  always_comb begin
    selCtrl.halfMode = isHalf;
    if (!fmtSel[4])     selCtrl.srcMode = SRC_ELEM;
    else if (fmtSel[3]) selCtrl.srcMode = SRC_IMM;
    else                selCtrl.srcMode = SRC_VECT;
    if (isHalf) selCtrl.laneIdx = BYTE_IDX_W'(fmtSel[HALF_IDX_W+1:2]);
    else        selCtrl.laneIdx = fmtSel[BYTE_IDX_W:1];

    laneCtrl.halfMode = isHalf;
    laneCtrl.op       = opDec;
    laneCtrl.illegal  = (opDec == OP_RSV)
                      | (!isHalf & (opDec == OP_SGN || opDec == OP_SRA))
                      | ( isHalf & (opDec == OP_ABD || opDec == OP_AVG));
  end
endmodule

// File: rtl/simd_alu_operand.sv
module simd_alu_operand
  import simd_alu_pkg::*;
#(
  parameter int unsigned VW = VEC_W,
  parameter int unsigned IW = IMM_W
) (
  input  logic [VW-1:0] vecB,
  input  logic [IW-1:0] immVal,
  input  selCtrl_t      selCtrl,
  output logic [VW-1:0] opB
);
  localparam int unsigned NB = VW / BYTE_W;
  localparam int unsigned NH = VW / HALF_W;

  logic [BYTE_W-1:0] byteElem, byteImm;
  logic [HALF_W-1:0] halfElem, halfImm;
  logic [VW-1:0]     byteRep, halfRep;

  assign byteElem = vecB[BYTE_W*selCtrl.laneIdx +: BYTE_W];
  assign halfElem = vecB[HALF_W*selCtrl.laneIdx[HALF_IDX_W-1:0] +: HALF_W];
  assign byteImm  = {{(BYTE_W-IW){1'b0}}, immVal};
  assign halfImm  = {{(HALF_W-IW){1'b0}}, immVal};

  for (genvar g = 0; g < NB; g++) begin : g_byteRep
    assign byteRep[BYTE_W*g +: BYTE_W] = (selCtrl.srcMode == SRC_IMM) ? byteImm : byteElem;
  end
  for (genvar g = 0; g < NH; g++) begin : g_halfRep
    assign halfRep[HALF_W*g +: HALF_W] = (selCtrl.srcMode == SRC_IMM) ? halfImm : halfElem;
  end

  assign opB = (selCtrl.srcMode == SRC_VECT) ? vecB
             : (selCtrl.halfMode ? halfRep : byteRep);
endmodule

// File: rtl/simd_alu_lanes.sv
module simd_alu_lanes
  import simd_alu_pkg::*;
#(
  parameter int unsigned VW = VEC_W
) (
  input  logic [VW-1:0] vecA,
  input  logic [VW-1:0] opB,
  input  laneCtrl_t     laneCtrl,
  output logic [VW-1:0] result
);
  localparam int unsigned NB = VW / BYTE_W;
  localparam int unsigned NH = VW / HALF_W;

  logic [VW-1:0] byteRes, halfRes;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0]  a, b, r;
    logic [8:0]  sum;
    logic [15:0] prod;
    assign a    = vecA[8*g +: 8];
    assign b    = opB[8*g +: 8];
    assign sum  = {1'b0, a} + {1'b0, b};
    assign prod = {8'd0, a} * {8'd0, b};
    always_comb begin
      unique case (laneCtrl.op)
        OP_AND:  r = a & b;
        OP_NOR:  r = ~(a | b);
        OP_OR:   r = a | b;
        OP_XOR:  r = a ^ b;
        OP_SLL:  r = a << b[2:0];
        OP_SRL:  r = a >> b[2:0];
        OP_ADD:  r = sum[8] ? 8'hFF : sum[7:0];
        OP_SUB:  r = (a < b) ? 8'h00 : a - b;
        OP_MIN:  r = (a < b) ? a : b;
        OP_MAX:  r = (a > b) ? a : b;
        OP_MUL:  r = (|prod[15:8]) ? 8'hFF : prod[7:0];
        OP_ABD:  r = (a >= b) ? a - b : b - a;
        OP_AVG:  r = 8'(({1'b0, sum} + 10'd1) >> 1);
        default: r = 8'h00;
      endcase
    end
    assign byteRes[8*g +: 8] = r;
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    logic signed [15:0] a, b;
    logic signed [16:0] sum, dif;
    logic signed [31:0] prod;
    logic        [15:0] r;
    assign a    = opA(g);
    assign b    = opB[16*g +: 16];
    assign sum  = {a[15], a} + {b[15], b};
    assign dif  = {a[15], a} - {b[15], b};
    assign prod = 32'(a) * 32'(b);
    always_comb begin
      unique case (laneCtrl.op)
        OP_AND:  r = a & b;
        OP_NOR:  r = ~(a | b);
        OP_OR:   r = a | b;
        OP_XOR:  r = a ^ b;
        OP_SLL:  r = a << b[3:0];
        OP_SRL:  r = a >> b[3:0];
        OP_SRA:  r = a >>> b[3:0];
        OP_ADD:  r = (sum[16] != sum[15]) ? (sum[16] ? 16'h8000 : 16'h7FFF) : sum[15:0];
        OP_SUB:  r = (dif[16] != dif[15]) ? (dif[16] ? 16'h8000 : 16'h7FFF) : dif[15:0];
        OP_MIN:  r = (a < b) ? a : b;
        OP_MAX:  r = (a > b) ? a : b;
        OP_MUL:  r = (prod > 32'sd32767) ? 16'h7FFF
                   : (prod < -32'sd32768) ? 16'h8000 : prod[15:0];
        OP_SGN:  r = (a == 16'sd0) ? 16'h0000
                   : !a[15] ? b
                   : (b == 16'sh8000) ? 16'h7FFF : -b;
        default: r = 16'h0000;
      endcase
    end
    assign halfRes[16*g +: 16] = r;
  end

  function automatic logic [15:0] opA(input int idx);
    return vecA[16*idx +: 16];
  endfunction

  assign result = laneCtrl.illegal ? '0 : (laneCtrl.halfMode ? halfRes : byteRes);
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
(
  input  logic [VEC_W-1:0] vecA,
  input  logic [VEC_W-1:0] vecB,
  input  logic [3:0]       opCode,
  input  logic [4:0]       fmtSel,
  input  logic [IMM_W-1:0] immVal,
  output logic [VEC_W-1:0] result,
  output logic             illegalOp
);
  selCtrl_t        selCtrl;
  laneCtrl_t       laneCtrl;
  logic [VEC_W-1:0] opB;

  simd_alu_ctrl u_ctrl (
    .opCode  (opCode),
    .fmtSel  (fmtSel),
    .selCtrl (selCtrl),
    .laneCtrl(laneCtrl)
  );

  simd_alu_operand #(.VW(VEC_W), .IW(IMM_W)) u_operand (
    .vecB   (vecB),
    .immVal (immVal),
    .selCtrl(selCtrl),
    .opB    (opB)
  );

  simd_alu_lanes #(.VW(VEC_W)) u_lanes (
    .vecA    (vecA),
    .opB     (opB),
    .laneCtrl(laneCtrl),
    .result  (result)
  );

  assign illegalOp = laneCtrl.illegal;
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk
  import simd_alu_pkg::*;
(
  input logic [VEC_W-1:0] vecA,
  input logic [VEC_W-1:0] vecB,
  input logic [3:0]       opCode,
  input logic [4:0]       fmtSel,
  input logic [IMM_W-1:0] immVal,
  input logic [VEC_W-1:0] result,
  input logic             illegalOp,
  input logic [VEC_W-1:0] opB
);
  // R11: a flagged combination never leaks a value
  always_comb begin
    if (illegalOp)
      a_r11_illegal_zero: assert (result == '0)
        else $error("illegal op produced nonzero result");
  end

  // R2: vector mode hands the second vector over untouched
  always_comb begin
    if (fmtSel[4:3] == 2'b10)
      a_r2_vector_pass: assert (opB == vecB)
        else $error("vector mode operand differs from vecB");
  end

  // R3: byte broadcast lane 0 carries the indexed byte of vecB
  always_comb begin
    if (!fmtSel[4] && !fmtSel[0])
      a_r3_elem_pick: assert (opB[7:0] == vecB[8*fmtSel[3:1] +: 8])
        else $error("broadcast lane mismatch");
  end

  for (genvar g = 0; g < BYTE_LANES; g++) begin : g_chkByte
    // R2: immediate broadcast is zero-extended into each byte lane
    always_comb begin
      if (fmtSel[4:3] == 2'b11 && !fmtSel[0])
        a_r2_imm_lane: assert (opB[8*g +: 8] == {{(8-IMM_W){1'b0}}, immVal})
          else $error("immediate lane %0d wrong", g);
    end
    // R8: byte minimum never exceeds either input lane
    always_comb begin
      if (!fmtSel[0] && opCode == 4'd8)
        a_r8_min_bound: assert (result[8*g +: 8] <= vecA[8*g +: 8] &&
                                result[8*g +: 8] <= opB[8*g +: 8])
          else $error("byte min above an input in lane %0d", g);
    end
    // R6: saturating byte add never drops below the first lane
    always_comb begin
      if (!fmtSel[0] && opCode == 4'd6)
        a_r6_no_wrap: assert (result[8*g +: 8] >= vecA[8*g +: 8])
          else $error("byte add wrapped in lane %0d", g);
    end
  end

  for (genvar g = 0; g < HALF_LANES; g++) begin : g_chkHalf
    // R9: a zero first lane yields zero under sign transfer
    always_comb begin
      if (fmtSel[0] && opCode == 4'd11 && vecA[16*g +: 16] == 16'd0)
        a_r9_zero_sign: assert (result[16*g +: 16] == 16'd0)
          else $error("sign transfer of zero lane %0d nonzero", g);
    end
  end
endmodule

bind simd_sat_alu simd_sat_alu_chk u_chk (
  .vecA     (vecA),
  .vecB     (vecB),
  .opCode   (opCode),
  .fmtSel   (fmtSel),
  .immVal   (immVal),
  .result   (result),
  .illegalOp(illegalOp),
  .opB      (opB)
);

// File: tb/simd_sat_alu_bench.sv
module simd_sat_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] vecA = '0, vecB = '0;
  logic [3:0]  opCode = '0;
  logic [4:0]  fmtSel = '0;
  logic [4:0]  immVal = '0;
  logic [63:0] result;
  logic        illegalOp;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  simd_sat_alu u_simd_sat_alu (
    .vecA(vecA), .vecB(vecB), .opCode(opCode), .fmtSel(fmtSel),
    .immVal(immVal), .result(result), .illegalOp(illegalOp)
  );

  function automatic int clampI(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // behavioural model: returns {illegal, result}
  function automatic logic [64:0] model(logic [63:0] a64, logic [63:0] b64,
                                        logic [3:0] op, logic [4:0] fs, logic [4:0] im);
    logic [63:0] res = '0;
    bit half = fs[0];
    bit ill;
    int lanes = half ? 4 : 8;
    int w = half ? 16 : 8;
    int idx = half ? int'(fs[3:2]) : int'(fs[3:1]);
    ill = (op == 15) || (!half && (op == 11 || op == 12)) || (half && (op == 13 || op == 14));
    if (ill) return {1'b1, 64'd0};
    for (int i = 0; i < lanes; i++) begin
      int a, b, r;
      logic [15:0] rawB;
      if (!fs[4])         rawB = 16'(b64 >> (w * idx));
      else if (!fs[3])    rawB = 16'(b64 >> (w * i));
      else                rawB = {11'd0, im};
      if (half) begin
        a = int'($signed(a64[16*i +: 16]));
        b = fs[4:3] == 2'b11 ? int'(im) : int'($signed(rawB));
      end else begin
        a = int'(a64[8*i +: 8]);
        b = int'(rawB[7:0]);
      end
      case (op)
        0: r = a & b;
        1: r = ~(a | b);
        2: r = a | b;
        3: r = a ^ b;
        4: r = half ? (a << (b & 15)) : (a << (b & 7));
        5: r = half ? ((a & 16'hFFFF) >> (b & 15)) : (a >> (b & 7));
        12: r = a >>> (b & 15);
        6: r = half ? clampI(a + b, -32768, 32767) : clampI(a + b, 0, 255);
        7: r = half ? clampI(a - b, -32768, 32767) : clampI(a - b, 0, 255);
        8: r = (a < b) ? a : b;
        9: r = (a > b) ? a : b;
        10: r = half ? clampI(a * b, -32768, 32767) : clampI(a * b, 0, 255);
        11: r = (a == 0) ? 0 : (a > 0) ? b : clampI(-b, -32768, 32767);
        13: r = (a > b) ? a - b : b - a;
        14: r = (a + b + 1) / 2;
        default: r = 0;
      endcase
      if (half) res[16*i +: 16] = r[15:0];
      else      res[8*i +: 8]   = r[7:0];
    end
    return {1'b0, res};
  endfunction

  function automatic string tagOf(logic [3:0] op, logic [4:0] fs);
    if (op == 15 || (!fs[0] && (op == 11 || op == 12)) || (fs[0] && (op == 13 || op == 14)))
      return "R11";
    case (op)
      0, 1, 2, 3: return "R4";
      4, 5, 12:   return "R5";
      6, 7:       return "R6";
      10:         return "R7";
      8, 9:       return "R8";
      11:         return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic runOne(logic [63:0] a, logic [63:0] b, logic [3:0] op,
                        logic [4:0] fs, logic [4:0] im, string req);
    logic [64:0] exp;
    @(posedge clk);
    vecA = a; vecB = b; opCode = op; fmtSel = fs; immVal = im;
    @(negedge clk);
    exp = model(a, b, op, fs, im);
    total++;
    if (result !== exp[63:0] || illegalOp !== exp[64]) begin
      bad++;
      $display("FAIL %s op=%0d fs=%b: result=%h illegal=%b expected result=%h illegal=%b",
               req, op, fs, result, illegalOp, exp[63:0], exp[64]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: zero inputs give zero result and no flag (R4)
    runOne('0, '0, 4'd0, 5'b10000, 5'd0, "R4 reset");
    // R4 logical
    runOne(64'hF0F0_1234_AAAA_00FF, 64'h0FF0_FFFF_5555_0F0F, 4'd0, 5'b10000, 0, "R4 and");
    runOne(64'hF0F0_1234_AAAA_00FF, 64'h0FF0_FFFF_5555_0F0F, 4'd1, 5'b10001, 0, "R4 nor");
    runOne(64'hF0F0_1234_AAAA_00FF, 64'h0FF0_FFFF_5555_0F0F, 4'd3, 5'b10000, 0, "R4 xor");
    // R1 signedness
    runOne(64'h8080_8080_8000_0001, 64'h0101_0101_0001_8000, 4'd8, 5'b10000, 0, "R1 byte min");
    runOne(64'h8080_8080_8000_0001, 64'h0101_0101_0001_8000, 4'd8, 5'b10001, 0, "R1 half min");
    // R2 immediate broadcast
    runOne('0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2, 5'b11000, 5'd31, "R2 imm byte");
    runOne('0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2, 5'b11001, 5'd17, "R2 imm half");
    // R3 lane broadcast
    runOne('0, 64'h8877_6655_4433_2211, 4'd2, 5'b01010, 0, "R3 byte idx5");
    runOne('0, 64'h8877_6655_4433_2211, 4'd2, 5'b01101, 0, "R3 half idx3");
    // R5 shift counts masked
    runOne(64'h8181_8181_8181_8181, 64'h1F1F_1F1F_0909_0101, 4'd4, 5'b10000, 0, "R5 sll byte");
    runOne(64'h8000_8000_4000_F000, 64'h0001_0013_0002_0004, 4'd12, 5'b10001, 0, "R5 sra half");
    runOne(64'h8000_8000_4000_F000, 64'h0001_0013_0002_0004, 4'd5, 5'b10001, 0, "R5 srl half");
    // R6 clamps
    runOne(64'hFF01_8000_0000_7F10, 64'h0101_8000_0001_7F20, 4'd6, 5'b10000, 0, "R6 byte add");
    runOne(64'h00FF_0010_0000_0001, 64'h0100_0020_0001_0002, 4'd7, 5'b10000, 0, "R6 byte sub");
    runOne(64'h7FFF_8000_1234_FFFF, 64'h0001_8000_1111_0001, 4'd6, 5'b10001, 0, "R6 half add");
    runOne(64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0007_8000, 4'd7, 5'b10001, 0, "R6 half sub");
    // R7 multiply
    runOne(64'h1010_0F11_FF02_0000, 64'h1010_1111_0102_FFFF, 4'd10, 5'b10000, 0, "R7 byte mul");
    runOne(64'h4000_8000_00FF_FFFF, 64'h0002_0002_0100_FFFF, 4'd10, 5'b10001, 0, "R7 half mul");
    // R9 sign transfer
    runOne(64'hFFFF_0000_0005_8000, 64'h8000_1234_8000_0007, 4'd11, 5'b10001, 0, "R9 sgn");
    // R10 byte only ops
    runOne(64'hFF00_1020_7F80_0001, 64'hFFFF_2010_807F_0100, 4'd13, 5'b10000, 0, "R10 absdiff");
    runOne(64'hFF00_1020_7F80_0001, 64'hFFFF_2010_807F_0100, 4'd14, 5'b10000, 0, "R10 avg");
    // R11 illegal combinations
    runOne(64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, 4'd11, 5'b10000, 0, "R11 sgn byte");
    runOne(64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, 4'd13, 5'b10001, 0, "R11 abd half");
    runOne(64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, 4'd15, 5'b10000, 0, "R11 rsv");
    // mixed sweep
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] op = 4'($urandom);
      logic [4:0] fs = 5'($urandom);
      runOne({$urandom, $urandom}, {$urandom, $urandom}, op, fs, 5'($urandom), tagOf(op, fs));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule